// File: doc/BRIEF.md
# Fault Status Byte Composer and Poller

This block assembles the 8-bit status byte that a gate-driver controller returns on every serial transaction. It merges three supply/thermal condition flags, which it holds until they have been read out once, with the latched load-fault flags of four output channels. The byte is a parallel value. A serial shifter outside this block loads it at the start of a transaction. Fault detection and the shifting itself sit in neighbouring blocks.

When load faults are present on more than one channel, the byte can name only one channel at a time. A poll pointer picks the first faulted channel at or after its own position, in ascending order. The pointer steps past that channel each time the transfer-complete strobe fires, so successive transactions walk through the faulted channels and wrap around. System flags are merged into every byte whatever channel is shown.

Top module: `fault_status_composer`

## Requirements
- R1: Byte layout: bits 7:6 carry the channel address, where channel 1 is 00, channel 2 is 01, channel 3 is 10 and channel 4 is 11. Bit 5 is the combined regulator/logic-supply undervoltage flag. Bit 4 is charge-pump undervoltage. Bit 3 is thermal warning. Bit 2 is open load, bit 1 is short to battery and bit 0 is short to ground. Each channel's load-flag input triplet uses the same order {open load, short to battery, short to ground}.
- R2: With no fault present, the byte reads 8'h00.
- R3: When only system flags are set, they appear in bits 5:3, and the address and load bits stay 0. For example, charge-pump undervoltage alone reads 8'h10.
- R4: When exactly one channel has load flags, the byte carries that channel's address and flags together with any held system flags. For example, short to battery on channel 3 reads 8'h82.
- R5: When several channels have load flags, successive transfers report them in ascending channel order. Channels with no flag are skipped, and the order wraps after the highest one (2, 3, 4, 2, ...).
- R6: A system flag stays set after its condition has gone, until one transfer-complete strobe has occurred while it was shown. That strobe then clears it.
- R7: A system condition that is active in the strobe cycle leaves its flag set after that strobe.
- R8: Without a strobe, the poll pointer does not move, and the reported channel stays fixed while the load flags are unchanged.
- R9: Reset clears all held system flags and returns the poll pointer to channel 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sup_uv_i | input | 1 | Live regulator/logic-supply undervoltage condition |
| cp_uv_i | input | 1 | Live charge-pump undervoltage condition |
| therm_i | input | 1 | Live thermal-warning condition |
| load_flags_i | input | 12 | Latched load flags, 3 per channel, channel 1 in bits 2:0 |
| xfer_done_i | input | 1 | One-cycle strobe: a status byte has been transferred |
| status_byte_o | output | 8 | Composed status byte |

## Verification
The checker assumes that the transfer-complete strobe is a synchronous single-cycle pulse. It also assumes that the load-flag inputs come from registers and only change between clock edges, so the held-flag and pointer properties can compare one cycle with the next. The bench drives every input on the falling edge and pulses the strobe for exactly one cycle. It never lets the load flags change in the same cycle as a strobe unless the scenario is meant to test that.

// File: rtl/fsc_pkg.sv
// Package: shared constants and the status byte layout for the composer.
// Assumes a four-channel driver, so the address field is two bits wide.
package fsc_pkg;
    localparam int NUM_CH = 4;
    localparam int LOAD_W = 3;
    localparam int SYS_W  = 3;
    localparam int CH_W   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;

    typedef struct packed {
        logic [CH_W-1:0] addr;
        logic            sup_uv;
        logic            cp_uv;
        logic            therm;
        logic            open_ld;
        logic            short_bat;
        logic            short_gnd;
    } status_t;
endpackage

// File: rtl/sys_flag_hold.sv
// Holds each system condition flag from the cycle it is seen until a
// transfer strobe arrives while the condition itself is low.
// Assumes: clear_i is a single-cycle strobe; live_i is synchronous.
module sys_flag_hold #(
    parameter int W = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] live_i,
    input  logic         clear_i,
    output logic [W-1:0] held_o
);
    logic [W-1:0] held_q;

    for (genvar b = 0; b < W; b++) begin : g_bit
        // Purpose: set on live condition, drop on a read strobe otherwise.
        always_ff @(posedge clk) begin
            if (!rst_n)
                held_q[b] <= 1'b0;
            else
                held_q[b] <= live_i[b] | (held_q[b] & ~clear_i);
        end
    end

    assign held_o = held_q;
endmodule

// File: rtl/chan_poll_sel.sv
// Round-robin poller: picks the first channel with any flag set, searching
// upward from the poll pointer and wrapping. The pointer steps past the
// chosen channel on each advance strobe when a channel was chosen.
// Assumes: flags_i is stable around the advance strobe.
module chan_poll_sel #(
    parameter int NUM_CH = 4,
    parameter int FLAG_W = 3,
    localparam int CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [NUM_CH*FLAG_W-1:0] flags_i,
    input  logic                     adv_i,
    output logic                     hit_o,
    output logic [CH_W-1:0]          sel_o,
    output logic [FLAG_W-1:0]        sel_flags_o
);
    logic [NUM_CH-1:0] any_vec;
    logic [CH_W-1:0]   ptr_q;
    logic [CH_W-1:0]   ptr_nxt;
    logic [CH_W-1:0]   sel;
    logic              hit;

    for (genvar c = 0; c < NUM_CH; c++) begin : g_any
        assign any_vec[c] = |flags_i[c*FLAG_W +: FLAG_W];
    end

    // Purpose: rotating search for the first faulted channel from the pointer.
    always_comb begin
        sel = '0;
        hit = 1'b0;
        for (int k = 0; k < NUM_CH; k++) begin
            int idx;
            idx = int'(ptr_q) + k;
            if (idx >= NUM_CH)
                idx = idx - NUM_CH;
            if (!hit && any_vec[idx]) begin
                hit = 1'b1;
                sel = CH_W'(idx);
            end
        end
    end

    // Purpose: pointer value one past the chosen channel, wrapping.
    always_comb begin
        if (sel == CH_W'(NUM_CH - 1))
            ptr_nxt = '0;
        else
            ptr_nxt = sel + 1'b1;
    end

    // Purpose: step the poll pointer only on a transfer with a reported channel.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ptr_q <= '0;
        else if (adv_i && hit)
            ptr_q <= ptr_nxt;
    end

    assign hit_o       = hit;
    assign sel_o       = sel;
    assign sel_flags_o = flags_i[int'(sel)*FLAG_W +: FLAG_W];
endmodule

// File: rtl/status_byte_pack.sv
// Packs held system flags and the chosen channel's load flags into the
// status layout. Address and load bits are forced to zero with no hit.
// Assumes: sys_i order is {supply UV, charge-pump UV, thermal}.
module status_byte_pack
    import fsc_pkg::*;
(
    input  logic              hit_i,
    input  logic [CH_W-1:0]   sel_i,
    input  logic [LOAD_W-1:0] load_i,
    input  logic [SYS_W-1:0]  sys_i,
    output status_t           stat_o
);
    // Purpose: field-by-field assembly of the status byte.
    always_comb begin
        stat_o.addr      = hit_i ? sel_i : '0;
        stat_o.sup_uv    = sys_i[2];
        stat_o.cp_uv     = sys_i[1];
        stat_o.therm     = sys_i[0];
        stat_o.open_ld   = hit_i & load_i[2];
        stat_o.short_bat = hit_i & load_i[1];
        stat_o.short_gnd = hit_i & load_i[0];
    end
endmodule

// File: rtl/fault_status_composer.sv
// Top: composes the status byte from held system flags and the polled
// channel's load flags. The byte is valid every cycle; xfer_done_i marks
// the cycle in which the shifter has consumed it.
module fault_status_composer
    import fsc_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     sup_uv_i,
    input  logic                     cp_uv_i,
    input  logic                     therm_i,
    input  logic [NUM_CH*LOAD_W-1:0] load_flags_i,
    input  logic                     xfer_done_i,
    output logic [7:0]               status_byte_o
);
    logic [SYS_W-1:0]  sys_held;
    logic              hit;
    logic [CH_W-1:0]   sel;
    logic [LOAD_W-1:0] sel_flags;
    status_t           stat;

    sys_flag_hold #(.W(SYS_W)) u_hold (
        .clk     (clk),
        .rst_n   (rst_n),
        .live_i  ({sup_uv_i, cp_uv_i, therm_i}),
        .clear_i (xfer_done_i),
        .held_o  (sys_held)
    );

    chan_poll_sel #(.NUM_CH(NUM_CH), .FLAG_W(LOAD_W)) u_poll (
        .clk         (clk),
        .rst_n       (rst_n),
        .flags_i     (load_flags_i),
        .adv_i       (xfer_done_i),
        .hit_o       (hit),
        .sel_o       (sel),
        .sel_flags_o (sel_flags)
    );

    status_byte_pack u_pack (
        .hit_i  (hit),
        .sel_i  (sel),
        .load_i (sel_flags),
        .sys_i  (sys_held),
        .stat_o (stat)
    );

    assign status_byte_o = stat;
endmodule

// File: rtl/fsc_checker.sv
// Checker: port-level properties of the status composer.
// Assumes a single-cycle strobe and registered load-flag inputs.
module fsc_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        sup_uv_i,
    input logic        cp_uv_i,
    input logic        therm_i,
    input logic [11:0] load_flags_i,
    input logic        xfer_done_i,
    input logic [7:0]  status_byte_o
);
    logic [2:0] live;
    assign live = {sup_uv_i, cp_uv_i, therm_i};

    // R6: shown system flags survive a cycle without a strobe
    p_hold_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !xfer_done_i |=> ((status_byte_o[5:3] & $past(status_byte_o[5:3])) == $past(status_byte_o[5:3])));

    // R7: after a strobe the flags equal exactly the conditions live at the strobe
    p_strobe_keeps_live_r7: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_done_i |=> (status_byte_o[5:3] == $past(live)));

    // R6: a live condition is shown in the next cycle
    p_live_sets_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (live != 3'b000) |=> ((status_byte_o[5:3] & $past(live)) == $past(live)));

    // R3: no load flags means address and load bits are zero
    p_no_load_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (load_flags_i == 12'h000) |-> (status_byte_o[7:6] == 2'b00 && status_byte_o[2:0] == 3'b000));

    // R4: some load flag means the byte shows a load flag
    p_load_shown_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (load_flags_i != 12'h000) |-> (status_byte_o[2:0] != 3'b000));

    // R8: no strobe and steady flags keep the address
    p_addr_steady_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !xfer_done_i |=> (!$stable(load_flags_i) || $stable(status_byte_o[7:6])));
endmodule

bind fault_status_composer fsc_checker u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .sup_uv_i      (sup_uv_i),
    .cp_uv_i       (cp_uv_i),
    .therm_i       (therm_i),
    .load_flags_i  (load_flags_i),
    .xfer_done_i   (xfer_done_i),
    .status_byte_o (status_byte_o)
);

// File: tb/sim_fault_status_composer.sv
module sim_fault_status_composer;
    localparam int PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        sup_uv, cp_uv, therm;
    logic [11:0] load;
    logic        xfer;
    logic [7:0]  stat;
    int          total = 0;
    int          bad = 0;
    bit          done = 1'b0;

    always #(PERIOD/2) clk = ~clk;

    fault_status_composer u0 (
        .clk           (clk),
        .rst_n         (rst_n),
        .sup_uv_i      (sup_uv),
        .cp_uv_i       (cp_uv),
        .therm_i       (therm),
        .load_flags_i  (load),
        .xfer_done_i   (xfer),
        .status_byte_o (stat)
    );

    task automatic chk(input logic [7:0] exp, input string tag);
        #1;
        total++;
        if (stat !== exp) begin
            bad++;
            $display("FAIL %s: got %h expected %h", tag, stat, exp);
        end
    endtask

    task automatic cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic strobe();
        @(negedge clk); xfer = 1'b1;
        @(negedge clk); xfer = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; sup_uv = 0; cp_uv = 0; therm = 0; load = '0; xfer = 0;
        cyc(2);
        rst_n = 1'b1;
    endtask

    // R2, R9: reset state
    task automatic t_reset();
        do_reset();
        chk(8'h00, "R2 R9 reset byte");
        cyc(3);
        chk(8'h00, "R2 idle no faults");
    endtask

    // R3, R1: system flags only; R6 clear by read
    task automatic t_sys_only();
        do_reset();
        cp_uv = 1'b1;
        cyc(1);
        chk(8'h10, "R3 charge-pump UV alone");
        therm = 1'b1;
        cyc(1);
        chk(8'h18, "R3 R1 two system flags");
        cp_uv = 1'b0; therm = 1'b0;
        cyc(1);
        chk(8'h18, "R6 flags held after condition ends");
        strobe();
        chk(8'h00, "R6 flags cleared by read");
    endtask

    // R6: hold across many cycles without strobe
    task automatic t_sticky_hold();
        do_reset();
        therm = 1'b1;
        cyc(1);
        therm = 1'b0;
        cyc(4);
        chk(8'h08, "R6 thermal held w/o strobe");
        strobe();
        chk(8'h00, "R6 thermal cleared");
    endtask

    // R7: condition active in the strobe cycle survives that strobe
    task automatic t_set_during();
        do_reset();
        @(negedge clk); xfer = 1'b1; sup_uv = 1'b1;
        @(negedge clk); xfer = 1'b0; sup_uv = 1'b0;
        chk(8'h20, "R7 R1 supply UV set in strobe cycle");
        strobe();
        chk(8'h00, "R7 cleared by next read");
        cp_uv = 1'b1;
        cyc(1);
        strobe();
        chk(8'h10, "R7 live condition across strobe");
        cp_uv = 1'b0;
        strobe();
        chk(8'h00, "R7 cleared once condition gone");
    endtask

    // R4: single-channel load faults, merged with system flags
    task automatic t_single_load();
        do_reset();
        load = 12'h000;
        load[8:6] = 3'b010;
        chk(8'h82, "R4 ch3 short to battery");
        cp_uv = 1'b1;
        cyc(1);
        chk(8'h92, "R4 ch3 with charge-pump UV");
        strobe();
        strobe();
        chk(8'h92, "R4 single channel stays after reads");
        cp_uv = 1'b0;
        load = 12'h000;
        load[5:3] = 3'b001;
        strobe();
        chk(8'h41, "R4 ch2 short to ground");
    endtask

    // R5, R8: several channels polled in ascending order with wrap
    task automatic t_multi_poll();
        do_reset();
        load = 12'h000;
        load[5:3]  = 3'b100;
        load[8:6]  = 3'b001;
        load[11:9] = 3'b010;
        chk(8'h44, "R5 first report ch2");
        cyc(5);
        chk(8'h44, "R8 no move without strobe");
        strobe();
        chk(8'h81, "R5 second report ch3");
        strobe();
        chk(8'hC2, "R5 third report ch4");
        strobe();
        chk(8'h44, "R5 wrap back to ch2");
        do_reset();
        load = 12'h000;
        load[2:0]  = 3'b111;
        load[11:9] = 3'b100;
        chk(8'h07, "R5 R1 ch1 all flags");
        strobe();
        chk(8'hC4, "R5 skip ch2 ch3 to ch4");
        strobe();
        chk(8'h07, "R5 wrap to ch1");
    endtask

    initial begin
        #(PERIOD * 20000);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; sup_uv = 0; cp_uv = 0; therm = 0; load = '0; xfer = 0;
        t_reset();
        t_sys_only();
        t_sticky_hold();
        t_set_during();
        t_single_load();
        t_multi_poll();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule